// File: doc/BRIEF.md
# Parallel NOR Flash Command Model

This block is a synthesizable stand-in for a 16-bit parallel NOR flash device. It is meant for FPGA prototypes and system benches that need firmware-visible flash behaviour: keyed command sequences, bit-clearing programming, timed erase with polled status, an identification mode and a parameter query table. The storage array is small and its size is set by parameters. The array is held in a block-RAM-style memory that powers up erased.

The host side is a plain synchronous bus that carries a word address, a write strobe with write data, and a read strobe. A read returns its word on `rd_data` two rising edges after the edge that samples `rd_en`, and `rd_data` holds its value until the next read. The command decoder only looks at the low `CMD_AW` address bits, so higher address bits alias. Commands use only the low data byte. A program operation commits in one cycle. An erase keeps the device busy for `max(ERASE_CYCLES, total words)` cycles. During that time reads return status instead of data.

Top module: `nfc_nor_flash`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `rd_data` is 0 and the device is in read-array mode. The array starts with every word at 0xFFFF.
- R2: In read-array mode, a read returns the stored word two rising edges after `rd_en` is sampled. `rd_data` stays unchanged until the next read completes.
- R3: A command sequence opens with two unlock writes: 0xAA at word address 0x555, then 0x55 at 0x2AA. Only address bits [10:0] are compared, so 0x5555 and 0x2AAA work the same way.
- R4: If any write in the middle of a sequence does not match the expected code and address, the device returns to read-array mode. That write takes no effect, and the array is left unchanged.
- R5: After unlock, 0x90 at 0x555 enters identification mode. In this mode offset 0 reads 0x00BF and offset 1 reads 0x236D. Writing 0xF0 returns the device to read-array mode.
- R6: Writing 0x98 at 0x55 enters query mode. Offsets 0x10/0x11/0x12 read 0x51/0x52/0x59 ('Q','R','Y'), and offset 0x2C reads 1. Offsets 0x2D/0x2E give SECTORS-1 as a low byte and a high byte. Offsets 0x2F/0x30 give the sector size in 256-byte units as a low byte and a high byte. 0xF0 exits.
- R7: The sequence unlock, then 0xA0 at 0x555, then a data write stores `old & data` at the data address. Programming 0x5555 and then 0xAA55 leaves 0x0055. Programming 0x55 and then 0xA5 leaves 0x05.
- R8: The sequence unlock, 0x80 at 0x555, unlock, then 0x30 at any address sets every word of that address's sector to 0xFFFF. Other sectors are left unchanged.
- R9: The same setup followed by 0x10 at 0x555 sets every word of the array to 0xFFFF.
- R10: An erase stays busy for max(ERASE_CYCLES, words) cycles. While busy, each read returns a status word with bit 7 = 0 and all bits other than bit 6 at 0. Bit 6 inverts on every read. All writes are ignored while busy, including 0xF0.
- R11: After unlock, 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs that word. 0x00 at any address leaves bypass mode.
- R12: Once bypass mode has been left, a bare 0xA0 and data write with no unlock leaves the target word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for both reads and writes |
| wr_en | input | 1 | Write strobe (command or data word) |
| wr_data | input | DATA_W | Write data; commands use bits [7:0] |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data or status word |

## Verification
The bench targets the following cases, each with the fault it exposes:
- **Address aliasing.** A decoder that compares the full address would reject the 0x5555 unlock.
- **Aborted sequences.** A state machine that does not abort on a wrong code would let a later stray 0xA0 program the array.
- **Erase status.** Bit 6 must toggle and bit 7 must stay clear while busy. An early end of busy is caught by reading about 45 cycles before the expected end. A wrong sweep range is caught by checking the neighbouring sectors for surviving data.
- **Bypass exit.** A program attempted after leaving bypass mode must leave its word erased. A model that stayed in bypass would write it.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY, ST_KEY1, ST_KEY2, ST_PROG,
    ST_ESET, ST_EKEY1, ST_EKEY2, ST_ERASE,
    ST_IDENT, ST_QUERY, ST_FAST, ST_FAST_PROG
  } nfc_state_e;

  typedef enum logic [1:0] {
    SRC_ARRAY, SRC_STATUS, SRC_INFO
  } nfc_src_e;

  localparam logic [7:0] K_FIRST     = 8'hAA;
  localparam logic [7:0] K_SECOND    = 8'h55;
  localparam logic [7:0] C_IDENT     = 8'h90;
  localparam logic [7:0] C_PROG      = 8'hA0;
  localparam logic [7:0] C_ESETUP    = 8'h80;
  localparam logic [7:0] C_SECT      = 8'h30;
  localparam logic [7:0] C_CHIP      = 8'h10;
  localparam logic [7:0] C_FAST      = 8'h20;
  localparam logic [7:0] C_FAST_EXIT = 8'h00;
  localparam logic [7:0] C_RESET     = 8'hF0;
  localparam logic [7:0] C_QUERY     = 8'h98;

  localparam int unsigned A_KEY1 = 32'h555;
  localparam int unsigned A_KEY2 = 32'h2AA;
  localparam int unsigned A_QRY  = 32'h055;

  localparam int STAT_TOG_BIT = 6;

endpackage

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
  import nfc_pkg::*;
#(
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_code,
  input  logic              erase_done,
  output nfc_state_e        state,
  output logic              prog_go,
  output logic              erase_go,
  output logic              erase_all
);

  localparam logic [CMD_AW-1:0] ADR_K1 = CMD_AW'(A_KEY1);
  localparam logic [CMD_AW-1:0] ADR_K2 = CMD_AW'(A_KEY2);
  localparam logic [CMD_AW-1:0] ADR_Q  = CMD_AW'(A_QRY);

  nfc_state_e nxt;
  logic at_k1, at_k2, at_q;

  assign at_k1 = (cmd_addr == ADR_K1);
  assign at_k2 = (cmd_addr == ADR_K2);
  assign at_q  = (cmd_addr == ADR_Q);

  always_comb begin
    nxt       = state;
    prog_go   = 1'b0;
    erase_go  = 1'b0;
    erase_all = 1'b0;
    if (state == ST_ERASE) begin
      if (erase_done) nxt = ST_ARRAY;
    end else if (wr_en) begin
      case (state)
        ST_ARRAY: begin
          if (at_k1 && cmd_code == K_FIRST)     nxt = ST_KEY1;
          else if (at_q && cmd_code == C_QUERY) nxt = ST_QUERY;
        end
        ST_KEY1:  nxt = (at_k2 && cmd_code == K_SECOND) ? ST_KEY2 : ST_ARRAY;
        ST_KEY2: begin
          nxt = ST_ARRAY;
          if (at_k1) begin
            case (cmd_code)
              C_PROG:   nxt = ST_PROG;
              C_IDENT:  nxt = ST_IDENT;
              C_ESETUP: nxt = ST_ESET;
              C_FAST:   nxt = ST_FAST;
              default:  nxt = ST_ARRAY;
            endcase
          end
        end
        ST_PROG: begin
          prog_go = 1'b1;
          nxt     = ST_ARRAY;
        end
        ST_ESET:  nxt = (at_k1 && cmd_code == K_FIRST)  ? ST_EKEY1 : ST_ARRAY;
        ST_EKEY1: nxt = (at_k2 && cmd_code == K_SECOND) ? ST_EKEY2 : ST_ARRAY;
        ST_EKEY2: begin
          nxt = ST_ARRAY;
          if (cmd_code == C_SECT) begin
            erase_go = 1'b1;
            nxt      = ST_ERASE;
          end else if (at_k1 && cmd_code == C_CHIP) begin
            erase_go  = 1'b1;
            erase_all = 1'b1;
            nxt       = ST_ERASE;
          end
        end
        ST_IDENT, ST_QUERY: begin
          if (cmd_code == C_RESET) nxt = ST_ARRAY;
        end
        ST_FAST: begin
          if (cmd_code == C_PROG)           nxt = ST_FAST_PROG;
          else if (cmd_code == C_FAST_EXIT) nxt = ST_ARRAY;
        end
        ST_FAST_PROG: begin
          prog_go = 1'b1;
          nxt     = ST_FAST;
        end
        default: nxt = ST_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ARRAY;
    else     state <= nxt;
  end

endmodule

// File: rtl/nfc_erase_seq.sv
module nfc_erase_seq #(
  parameter int IDX_W  = 9,
  parameter int SEC_W  = 7,
  parameter int TICKS  = 600,
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   chip,
  input  logic [IDX_W-SEC_W-1:0] sect,
  output logic                   busy,
  output logic                   done,
  output logic                   we,
  output logic [IDX_W-1:0]       waddr,
  output logic [DATA_W-1:0]      wdata
);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] ptr, last;
  logic             sweeping;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sweeping <= 1'b0;
      cnt      <= '0;
      ptr      <= '0;
      last     <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      sweeping <= 1'b1;
      cnt      <= CNT_W'(TICKS - 1);
      if (chip) begin
        ptr  <= '0;
        last <= '1;
      end else begin
        ptr  <= {sect, {SEC_W{1'b0}}};
        last <= {sect, {SEC_W{1'b1}}};
      end
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == '0) busy <= 1'b0;
      if (sweeping) begin
        if (ptr == last) sweeping <= 1'b0;
        else             ptr <= ptr + 1'b1;
      end
    end
  end

  assign done  = busy && (cnt == '0);
  assign we    = busy && sweeping;
  assign waddr = ptr;
  assign wdata = '1;

endmodule

// File: rtl/nfc_info_rom.sv
module nfc_info_rom #(
  parameter int DATA_W     = 16,
  parameter int SECTORS    = 4,
  parameter int SIZE_UNITS = 1
) (
  input  logic              ident,
  input  logic [7:0]        off,
  output logic [DATA_W-1:0] val
);

  localparam logic [15:0] SCNT = 16'(SECTORS - 1);
  localparam logic [15:0] SU   = 16'(SIZE_UNITS);

  always_comb begin
    val = '0;
    if (ident) begin
      case (off)
        8'h00:   val = DATA_W'(16'h00BF);
        8'h01:   val = DATA_W'(16'h236D);
        default: val = '0;
      endcase
    end else begin
      case (off)
        8'h10:   val = DATA_W'(16'h0051);
        8'h11:   val = DATA_W'(16'h0052);
        8'h12:   val = DATA_W'(16'h0059);
        8'h2C:   val = DATA_W'(16'h0001);
        8'h2D:   val = DATA_W'(SCNT[7:0]);
        8'h2E:   val = DATA_W'(SCNT[15:8]);
        8'h2F:   val = DATA_W'(SU[7:0]);
        8'h30:   val = DATA_W'(SU[15:8]);
        default: val = '0;
      endcase
    end
  end

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 9,
  parameter int WORDS  = 512
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rq
);

  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end

endmodule

// File: rtl/nfc_nor_flash.sv
module nfc_nor_flash
  import nfc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 16,
  parameter int CMD_AW       = 11,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 128,
  parameter int ERASE_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS       = SECTORS * SECTOR_WORDS;
  localparam int IDX_W       = $clog2(WORDS);
  localparam int SEC_W       = $clog2(SECTOR_WORDS);
  localparam int ERASE_TICKS = (ERASE_CYCLES > WORDS) ? ERASE_CYCLES : WORDS;
  localparam int CNT_W       = $clog2(ERASE_TICKS + 1);
  localparam int SIZE_UNITS  = (SECTOR_WORDS * (DATA_W / 8)) / 256;

  logic [IDX_W-1:0] idx;
  logic             unused_addr_hi;
  assign idx            = addr[IDX_W-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:CMD_AW];

  nfc_state_e state;
  logic prog_go, erase_go, erase_all;
  logic er_busy, er_done, er_we;
  logic [IDX_W-1:0]  er_waddr;
  logic [DATA_W-1:0] er_wdata, info_val, rq;

  nfc_cmd_fsm #(.CMD_AW(CMD_AW)) fsm_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd_addr(addr[CMD_AW-1:0]),
    .cmd_code(wr_data[7:0]), .erase_done(er_done), .state(state),
    .prog_go(prog_go), .erase_go(erase_go), .erase_all(erase_all)
  );

  nfc_erase_seq #(
    .IDX_W(IDX_W), .SEC_W(SEC_W), .TICKS(ERASE_TICKS), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) seq_i (
    .clk(clk), .rst(rst), .start(erase_go), .chip(erase_all),
    .sect(idx[IDX_W-1:SEC_W]), .busy(er_busy), .done(er_done),
    .we(er_we), .waddr(er_waddr), .wdata(er_wdata)
  );

  nfc_info_rom #(.DATA_W(DATA_W), .SECTORS(SECTORS), .SIZE_UNITS(SIZE_UNITS)) rom_i (
    .ident(state == ST_IDENT), .off(addr[7:0]), .val(info_val)
  );

  // Program is read-modify-write: the array reads the target on the data
  // write, and the ANDed word is written back on the following cycle.
  logic              pend_v;
  logic [IDX_W-1:0]  pend_a;
  logic [DATA_W-1:0] pend_d;
  logic              arr_we;
  logic [IDX_W-1:0]  arr_waddr;
  logic [DATA_W-1:0] arr_wdata;

  assign arr_we    = pend_v | er_we;
  assign arr_waddr = pend_v ? pend_a : er_waddr;
  assign arr_wdata = pend_v ? (rq & pend_d) : er_wdata;

  nfc_array #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WORDS(WORDS)) arr_i (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(idx), .rq(rq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else begin
      pend_v <= prog_go;
      if (prog_go) begin
        pend_a <= idx;
        pend_d <= wr_data;
      end
    end
  end

  // Read pipeline: stage 1 captures source and side values, stage 2 selects.
  logic              tog, s1_v, s1_fwd;
  nfc_src_e          s1_src;
  logic [DATA_W-1:0] s1_info, s1_stat, s1_fwdv;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      s1_v    <= 1'b0;
      s1_src  <= SRC_ARRAY;
      s1_info <= '0;
      s1_stat <= '0;
      s1_fwd  <= 1'b0;
      s1_fwdv <= '0;
      rd_data <= '0;
    end else begin
      s1_v <= rd_en;
      if (rd_en) begin
        if (er_busy) tog <= ~tog;
        if (er_busy)                                     s1_src <= SRC_STATUS;
        else if (state == ST_IDENT || state == ST_QUERY) s1_src <= SRC_INFO;
        else                                             s1_src <= SRC_ARRAY;
        s1_info <= info_val;
        s1_stat <= DATA_W'(tog) << STAT_TOG_BIT;
        s1_fwd  <= pend_v && (pend_a == idx);
        s1_fwdv <= rq & pend_d;
      end
      if (s1_v) begin
        case (s1_src)
          SRC_STATUS: rd_data <= s1_stat;
          SRC_INFO:   rd_data <= s1_info;
          default:    rd_data <= s1_fwd ? s1_fwdv : rq;
        endcase
      end
    end
  end

endmodule

// File: rtl/nfc_nor_flash_chk.sv
module nfc_nor_flash_chk
  import nfc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input nfc_state_e        state,
  input logic              er_busy,
  input logic              prog_go,
  input logic              tog,
  input logic              s1_v,
  input nfc_src_e          s1_src,
  input logic              pend_v,
  input logic [DATA_W-1:0] arr_wdata,
  input logic [DATA_W-1:0] rq
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && state == ST_ARRAY));

  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> $stable(rd_data));

  p_and_only_r7: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> ((arr_wdata & ~rq) == '0));

  p_erase_exit_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(er_busy) |-> (state == ST_ARRAY));

  p_busy_pair_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE) == er_busy);

  p_no_prog_busy_r10: assert property (@(posedge clk) disable iff (rst)
    prog_go |-> !er_busy);

  p_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && er_busy) |=> (tog != $past(tog)));

  p_stat_dq7_r10: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_src == SRC_STATUS) |=> (rd_data[7] == 1'b0));

endmodule

bind nfc_nor_flash nfc_nor_flash_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data), .state(state),
  .er_busy(er_busy), .prog_go(prog_go), .tog(tog), .s1_v(s1_v),
  .s1_src(s1_src), .pend_v(pend_v), .arr_wdata(arr_wdata), .rq(rq)
);

// File: tb/nfc_nor_flash_tb_top.sv
module nfc_nor_flash_tb_top;

  localparam int SECTORS = 4;
  localparam int SW      = 128;
  localparam int WORDS   = SECTORS * SW;
  localparam int ECYC    = 600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nfc_nor_flash #(
    .SECTORS(SECTORS), .SECTOR_WORDS(SW), .ERASE_CYCLES(ECYC)
  ) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic unlock(input logic [15:0] a1, input logic [15:0] a2);
    wr(a1, 16'h00AA);
    wr(a2, 16'h0055);
  endtask

  task automatic program_word(input logic [15:0] a, input logic [15:0] d);
    unlock(16'h0555, 16'h02AA);
    wr(16'h0555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase_cmd(input logic [15:0] a, input logic [7:0] code);
    unlock(16'h0555, 16'h02AA);
    wr(16'h0555, 16'h0080);
    unlock(16'h0555, 16'h02AA);
    wr(a, {8'h00, code});
  endtask

  task automatic range_blank(input string tag, input int lo, input int hi);
    int bad = 0;
    logic [15:0] v;
    for (int i = lo; i <= hi; i++) begin
      rd(16'(i), v);
      if (v !== 16'hFFFF) bad++;
    end
    chk(tag, 16'(bad), 16'h0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2, s0, s1, s2;
    int t0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rd_data during reset", rd_data, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 16'h0000);

    // R1/R2: fresh array is all ones, read latency
    range_blank("R1 R2 fresh array blank", 0, WORDS - 1);

    // R5: identification mode
    unlock(16'h0555, 16'h02AA);
    wr(16'h0555, 16'h0090);
    rd(16'h0000, v); chk("R5 manufacturer id", v, 16'h00BF);
    rd(16'h0001, v); chk("R5 device id", v, 16'h236D);
    wr(16'h0000, 16'h00F0);
    rd(16'h0000, v); chk("R5 reset to array", v, 16'hFFFF);

    // R3: high address bits ignored during unlock
    unlock(16'h5555, 16'h2AAA);
    wr(16'h5555, 16'h0090);
    rd(16'h0000, v); chk("R3 aliased unlock id", v, 16'h00BF);
    wr(16'h0000, 16'h00F0);

    // R6: query table
    wr(16'h0055, 16'h0098);
    rd(16'h0010, v); chk("R6 Q", v, 16'h0051);
    rd(16'h0011, v); chk("R6 R", v, 16'h0052);
    rd(16'h0012, v); chk("R6 Y", v, 16'h0059);
    rd(16'h002C, v); chk("R6 regions", v, 16'h0001);
    rd(16'h002D, v); chk("R6 count lo", v, 16'((SECTORS - 1) & 255));
    rd(16'h002E, v); chk("R6 count hi", v, 16'((SECTORS - 1) >> 8));
    rd(16'h002F, v); chk("R6 size lo", v, 16'(((SW * 2) / 256) & 255));
    rd(16'h0030, v); chk("R6 size hi", v, 16'(((SW * 2) / 256) >> 8));
    wr(16'h0000, 16'h00F0);
    rd(16'h0010, v); chk("R6 exit to array", v, 16'hFFFF);

    // R7: program ANDs into stored word; R2 hold
    program_word(16'd20, 16'h5555);
    rd(16'd20, v); chk("R7 program 5555", v, 16'h5555);
    program_word(16'd20, 16'hAA55);
    rd(16'd20, v); chk("R7 program AND", v, 16'h0055);
    repeat (4) @(negedge clk);
    chk("R2 rd_data holds", rd_data, 16'h0055);
    program_word(16'd21, 16'h0055);
    program_word(16'd21, 16'h00A5);
    rd(16'd21, v); chk("R7 low byte 05", v, 16'h0005);

    // R4: aborted sequences leave array untouched
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0012);
    wr(16'h0555, 16'h00A0);
    wr(16'd40, 16'h0000);
    rd(16'd40, v); chk("R4 bad second key", v, 16'hFFFF);
    unlock(16'h0555, 16'h02AA);
    wr(16'h0123, 16'h00A0);
    wr(16'd41, 16'h0000);
    rd(16'd41, v); chk("R4 command at wrong address", v, 16'hFFFF);

    // R8/R10: sector erase of sector 1
    program_word(16'd5, 16'h1234);
    program_word(16'(SW + 2), 16'h00FF);
    program_word(16'(2 * SW + 44), 16'hABCD);
    erase_cmd(16'(SW + 7), 8'h30);
    t0 = cyc;
    rd(16'(SW + 7), s0);
    rd(16'(SW + 7), s1);
    chk("R10 status bit7 and others zero", s0 & 16'hFFBF, 16'h0000);
    chk("R10 status bit6 toggles", s0 ^ s1, 16'h0040);
    wr(16'h0000, 16'h00F0);
    program_word(16'd5, 16'h0000);
    rd(16'(SW + 7), s2);
    chk("R10 writes ignored while busy", s2, s0);
    while (cyc < t0 + ECYC - 45) @(negedge clk);
    rd(16'(SW + 7), v);
    chk("R10 still busy near end", v & 16'hFFBF, 16'h0000);
    while (cyc < t0 + ECYC + 40) @(negedge clk);
    rd(16'(SW + 7), v);
    rd(16'(SW + 7), v2);
    chk("R10 stable after erase", v ^ v2, 16'h0000);
    range_blank("R8 sector 1 blank", SW, 2 * SW - 1);
    rd(16'd5, v); chk("R8 sector 0 kept", v, 16'h1234);
    rd(16'(2 * SW + 44), v); chk("R8 sector 2 kept", v, 16'hABCD);

    // R9/R10: chip erase
    erase_cmd(16'h0555, 8'h10);
    t0 = cyc;
    rd(16'h0000, s0);
    rd(16'h0000, s1);
    chk("R10 chip status bit7", s0 & 16'h0080, 16'h0000);
    chk("R10 chip toggle", s0 ^ s1, 16'h0040);
    while (cyc < t0 + ECYC + 40) @(negedge clk);
    range_blank("R9 chip blank", 0, WORDS - 1);

    // R11/R12: bypass programming
    unlock(16'h0555, 16'h02AA);
    wr(16'h0555, 16'h0020);
    wr(16'h0555, 16'h00A0); wr(16'd0, 16'h0001);
    wr(16'h0555, 16'h00A0); wr(16'd1, 16'h0023);
    wr(16'h0555, 16'h00A0); wr(16'd2, 16'h0045);
    wr(16'd3, 16'h00A0);    wr(16'd3, 16'h0067);
    wr(16'd0, 16'h0000);
    wr(16'h0555, 16'h00A0); wr(16'd4, 16'h0089);
    rd(16'd0, v); chk("R11 bypass word 0", v, 16'h0001);
    rd(16'd1, v); chk("R11 bypass word 1", v, 16'h0023);
    rd(16'd2, v); chk("R11 bypass word 2", v, 16'h0045);
    rd(16'd3, v); chk("R11 bypass any-address command", v, 16'h0067);
    rd(16'd4, v); chk("R12 program after exit ignored", v, 16'hFFFF);

    finish_run();
  end

endmodule